// File: doc/BRIEF.md
# DRAM Command Timing Checker

This block tracks the command history of a multi-bank DRAM device and computes, for any proposed command, the earliest clock cycle at which it may legally be placed. A scheduler presents a command kind (activate, read, write or precharge), a bank, a bank group and a lower-bound cycle (the cycle at which the request becomes available). The block answers combinationally with the earliest legal cycle. When the scheduler commits the command, the block records it at that cycle on the same clock edge.

Timing values are 8-bit runtime inputs, so one instance serves several device speed grades. Three mode inputs select the device flavour:
- a two-activate window in place of the four-activate window,
- short/long timings keyed on bank-group change,
- a one-cycle pad on write-related intervals for a low-power family.

An activate that would share a cycle with an already placed column command is pushed later, one cycle at a time, until its slot is free. A column command aimed at a bank with no open row is flagged as an error and cannot be committed.

Top module: `dram_timing_checker`

## Requirements
- R1: With cmd_i = 0 (activate), earliest_o is the largest of now_i, the most recent activate plus tRRD, the addressed bank's last precharge plus tRP, and the activate-window term; a term whose event has not yet happened since reset is left out.
- R2: The activate-window term is the fourth-most-recent activate plus tFAW; with two_act_win_i = 1 it is instead the second-most-recent activate plus tTAW.
- R3: With cmd_i = 1 (read) or 2 (write), earliest_o is the largest of now_i, the bank's activate plus tRCD, and the last column command plus a gap. The gap is tCCD for the same kind, WL + burst + tWTR for write then read, and RL + burst + 2 - WL (floored at zero) for read then write.
- R4: With grp_mode_i = 1, tCCD, tRRD and tWTR take their long values when the requested bank group equals the group of the previous command of the same class (activate or column), and their short values otherwise; with grp_mode_i = 0 the short values are always used.
- R5: With cmd_i = 3 (precharge), earliest_o is the largest of now_i, the bank's activate plus tRAS when the bank is open, and the last column command plus tRTP (after a read) or WL + burst + tWR (after a write).
- R6: With wr_pad_i = 1, one cycle is added to the write-to-read gap and to the write-to-precharge interval.
- R7: An activate whose cycle equals that of any of the last four column commands is delayed by one cycle, repeatedly, until it matches none of them.
- R8: A read or write to a bank with no open row raises err_o; committing it then changes no tracked state.
- R9: When issue_i is high at a rising edge and err_o is low, the command is recorded at cycle earliest_o. An activate opens its bank and a precharge closes it. After reset, no history exists and all banks are closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | Command kind: 0 activate, 1 read, 2 write, 3 precharge |
| bank_i | input | 4 | Target bank |
| bg_i | input | 2 | Target bank group |
| now_i | input | 16 | Lower bound cycle for the command |
| issue_i | input | 1 | Commit the presented command at earliest_o |
| grp_mode_i | input | 1 | Enable short/long bank-group timings |
| two_act_win_i | input | 1 | Use two-activate window instead of four |
| wr_pad_i | input | 1 | Add one cycle to write-to-read and write-to-precharge |
| rrd_s_i | input | 8 | Activate-to-activate, different group |
| rrd_l_i | input | 8 | Activate-to-activate, same group |
| rp_i | input | 8 | Precharge-to-activate, same bank |
| faw_i | input | 8 | Four-activate window |
| taw_i | input | 8 | Two-activate window |
| rcd_i | input | 8 | Activate-to-column, same bank |
| ccd_s_i | input | 8 | Column-to-column, different group |
| ccd_l_i | input | 8 | Column-to-column, same group |
| wtr_s_i | input | 8 | Write-to-read recovery, different group |
| wtr_l_i | input | 8 | Write-to-read recovery, same group |
| ras_i | input | 8 | Activate-to-precharge, same bank |
| rtp_i | input | 8 | Read-to-precharge |
| wr_i | input | 8 | Write recovery |
| wl_i | input | 8 | Write latency |
| rl_i | input | 8 | Read latency |
| burst_i | input | 8 | Burst duration in clock cycles |
| earliest_o | output | 16 | Earliest legal cycle for the presented command |
| err_o | output | 1 | Column command to a closed bank |

## Verification
The bench drives the activate window to exactly four entries, then asks for a fifth activate. A checker that read the wrong history slot, or the wrong slot in two-activate mode, returns a cycle set by the rank-spacing term alone. It places an activate on top of three back-to-back reads, so a push-back that stops after one step lands on an occupied cycle. It walks every column-direction change with and without bank-group mode and with the write pad. A swapped short/long choice or a missing pad shows as a cycle off by the difference. It commits a read to a closed bank and then reads back the column history through a later query, so a block that leaked the rejected command into its registers is caught.

// File: rtl/dram_tc_pkg.sv
package dram_tc_pkg;
  localparam int unsigned TIME_W = 8;

  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;

  typedef struct packed {
    logic [TIME_W-1:0] rrd_s;
    logic [TIME_W-1:0] rrd_l;
    logic [TIME_W-1:0] rp;
    logic [TIME_W-1:0] faw;
    logic [TIME_W-1:0] taw;
    logic [TIME_W-1:0] rcd;
    logic [TIME_W-1:0] ccd_s;
    logic [TIME_W-1:0] ccd_l;
    logic [TIME_W-1:0] wtr_s;
    logic [TIME_W-1:0] wtr_l;
    logic [TIME_W-1:0] ras;
    logic [TIME_W-1:0] rtp;
    logic [TIME_W-1:0] wr;
    logic [TIME_W-1:0] wl;
    logic [TIME_W-1:0] rl;
    logic [TIME_W-1:0] burst;
  } t_cfg_t;
endpackage

// File: rtl/dram_act_window.sv
module dram_act_window
  import dram_tc_pkg::*;
#(
  parameter int unsigned CYC_W = 16,
  parameter int unsigned BG_W  = 2,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [CYC_W-1:0] time_i,
  input  logic [BG_W-1:0]  bg_i,
  input  logic             two_win_i,
  input  t_cfg_t           cfg_i,
  output logic [CYC_W-1:0] last_o,
  output logic [BG_W-1:0]  last_bg_o,
  output logic             last_v_o,
  output logic [CYC_W-1:0] win_o,
  output logic             win_v_o
);
  localparam int unsigned PAD      = CYC_W - TIME_W;
  localparam int unsigned SLOT_TWO = 1;
  localparam int unsigned SLOT_FOUR = 3;

  function automatic logic [CYC_W-1:0] ext(input logic [TIME_W-1:0] v);
    return {{PAD{1'b0}}, v};
  endfunction

  logic [CYC_W-1:0] t_q [DEPTH];
  logic [DEPTH-1:0] v_q;
  logic [BG_W-1:0]  bg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q[0] <= '0;
      v_q    <= '0;
      bg_q   <= '0;
    end else if (push_i) begin
      t_q[0] <= time_i;
      v_q    <= {v_q[DEPTH-2:0], 1'b1};
      bg_q   <= bg_i;
    end
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     t_q[g] <= '0;
      else if (push_i) t_q[g] <= t_q[g-1];
    end
  end

  assign last_o    = t_q[0];
  assign last_bg_o = bg_q;
  assign last_v_o  = v_q[0];
  assign win_o     = two_win_i ? t_q[SLOT_TWO] + ext(cfg_i.taw)
                               : t_q[SLOT_FOUR] + ext(cfg_i.faw);
  assign win_v_o   = two_win_i ? v_q[SLOT_TWO] : v_q[SLOT_FOUR];
endmodule

// File: rtl/dram_bank_table.sv
module dram_bank_table #(
  parameter int unsigned NUM_BANKS = 16,
  parameter int unsigned CYC_W     = 16,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_we_i,
  input  logic              pre_we_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [CYC_W-1:0]  time_i,
  output logic [CYC_W-1:0]  act_t_o,
  output logic              open_o,
  output logic [CYC_W-1:0]  pre_t_o,
  output logic              pre_v_o
);
  logic [CYC_W-1:0]     act_q [NUM_BANKS];
  logic [CYC_W-1:0]     pre_q [NUM_BANKS];
  logic [NUM_BANKS-1:0] open_q;
  logic [NUM_BANKS-1:0] pre_v_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank_i == BANK_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_q[b]   <= '0;
        pre_q[b]   <= '0;
        open_q[b]  <= 1'b0;
        pre_v_q[b] <= 1'b0;
      end else if (hit) begin
        if (act_we_i) begin
          act_q[b]  <= time_i;
          open_q[b] <= 1'b1;
        end else if (pre_we_i) begin
          pre_q[b]   <= time_i;
          pre_v_q[b] <= 1'b1;
          open_q[b]  <= 1'b0;
        end
      end
    end
  end

  assign act_t_o = act_q[bank_i];
  assign open_o  = open_q[bank_i];
  assign pre_t_o = pre_q[bank_i];
  assign pre_v_o = pre_v_q[bank_i];
endmodule

// File: rtl/dram_col_tracker.sv
module dram_col_tracker
  import dram_tc_pkg::*;
#(
  parameter int unsigned CYC_W = 16,
  parameter int unsigned BG_W  = 2,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             push_rd_i,
  input  logic [CYC_W-1:0] time_i,
  input  logic [BG_W-1:0]  bg_i,
  input  logic             req_rd_i,
  input  logic [BG_W-1:0]  req_bg_i,
  input  logic             grp_mode_i,
  input  logic             wr_pad_i,
  input  t_cfg_t           cfg_i,
  input  logic [CYC_W-1:0] cand_i,
  output logic             col_v_o,
  output logic [CYC_W-1:0] col_term_o,
  output logic [CYC_W-1:0] pre_term_o,
  output logic [CYC_W-1:0] cand_o
);
  localparam int unsigned PAD = CYC_W - TIME_W;

  function automatic logic [CYC_W-1:0] ext(input logic [TIME_W-1:0] v);
    return {{PAD{1'b0}}, v};
  endfunction

  logic [CYC_W-1:0] t_q [DEPTH];
  logic [DEPTH-1:0] v_q;
  logic             rd_q;
  logic [BG_W-1:0]  bg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q[0] <= '0;
      v_q    <= '0;
      rd_q   <= 1'b0;
      bg_q   <= '0;
    end else if (push_i) begin
      t_q[0] <= time_i;
      v_q    <= {v_q[DEPTH-2:0], 1'b1};
      rd_q   <= push_rd_i;
      bg_q   <= bg_i;
    end
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     t_q[g] <= '0;
      else if (push_i) t_q[g] <= t_q[g-1];
    end
  end

  logic             same_bg;
  logic [CYC_W-1:0] ccd, wtr, pad, gap, rw_sum, wr_rec;

  assign same_bg = grp_mode_i && (req_bg_i == bg_q);
  assign ccd     = same_bg ? ext(cfg_i.ccd_l) : ext(cfg_i.ccd_s);
  assign wtr     = same_bg ? ext(cfg_i.wtr_l) : ext(cfg_i.wtr_s);
  assign pad     = {{(CYC_W-1){1'b0}}, wr_pad_i};
  assign rw_sum  = ext(cfg_i.rl) + ext(cfg_i.burst) + CYC_W'(2);
  assign wr_rec  = ext(cfg_i.wl) + ext(cfg_i.burst) + ext(cfg_i.wr) + pad;

  always_comb begin
    if (rd_q == req_rd_i)
      gap = ccd;
    else if (req_rd_i)
      gap = ext(cfg_i.wl) + ext(cfg_i.burst) + wtr + pad;
    else
      gap = (rw_sum > ext(cfg_i.wl)) ? rw_sum - ext(cfg_i.wl) : '0;
  end

  assign col_v_o    = v_q[0];
  assign col_term_o = t_q[0] + gap;
  assign pre_term_o = t_q[0] + (rd_q ? ext(cfg_i.rtp) : wr_rec);

  // DEPTH passes suffice: each bump consumes one distinct history entry
  always_comb begin
    logic hit;
    cand_o = cand_i;
    for (int p = 0; p < DEPTH; p++) begin
      hit = 1'b0;
      for (int e = 0; e < DEPTH; e++)
        if (v_q[e] && t_q[e] == cand_o) hit = 1'b1;
      if (hit) cand_o = cand_o + CYC_W'(1);
    end
  end
endmodule

// File: rtl/dram_timing_checker.sv
module dram_timing_checker
  import dram_tc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 16,
  parameter int unsigned NUM_BGS   = 4,
  parameter int unsigned CYC_W     = 16,
  parameter int unsigned ACT_HIST  = 4,
  parameter int unsigned COL_HIST  = 4,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
  localparam int unsigned BG_W     = $clog2(NUM_BGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [BG_W-1:0]   bg_i,
  input  logic [CYC_W-1:0]  now_i,
  input  logic              issue_i,
  input  logic              grp_mode_i,
  input  logic              two_act_win_i,
  input  logic              wr_pad_i,
  input  logic [TIME_W-1:0] rrd_s_i,
  input  logic [TIME_W-1:0] rrd_l_i,
  input  logic [TIME_W-1:0] rp_i,
  input  logic [TIME_W-1:0] faw_i,
  input  logic [TIME_W-1:0] taw_i,
  input  logic [TIME_W-1:0] rcd_i,
  input  logic [TIME_W-1:0] ccd_s_i,
  input  logic [TIME_W-1:0] ccd_l_i,
  input  logic [TIME_W-1:0] wtr_s_i,
  input  logic [TIME_W-1:0] wtr_l_i,
  input  logic [TIME_W-1:0] ras_i,
  input  logic [TIME_W-1:0] rtp_i,
  input  logic [TIME_W-1:0] wr_i,
  input  logic [TIME_W-1:0] wl_i,
  input  logic [TIME_W-1:0] rl_i,
  input  logic [TIME_W-1:0] burst_i,
  output logic [CYC_W-1:0]  earliest_o,
  output logic              err_o
);
  localparam int unsigned PAD = CYC_W - TIME_W;

  function automatic logic [CYC_W-1:0] ext(input logic [TIME_W-1:0] v);
    return {{PAD{1'b0}}, v};
  endfunction

  function automatic logic [CYC_W-1:0] vmax(input logic [CYC_W-1:0] a,
                                            input logic [CYC_W-1:0] b,
                                            input logic b_v);
    return (b_v && b > a) ? b : a;
  endfunction

  t_cfg_t cfg;
  assign cfg = '{rrd_s: rrd_s_i, rrd_l: rrd_l_i, rp: rp_i, faw: faw_i, taw: taw_i,
                 rcd: rcd_i, ccd_s: ccd_s_i, ccd_l: ccd_l_i, wtr_s: wtr_s_i,
                 wtr_l: wtr_l_i, ras: ras_i, rtp: rtp_i, wr: wr_i, wl: wl_i,
                 rl: rl_i, burst: burst_i};

  cmd_e cmd;
  logic is_act, is_col, is_pre, accept;
  assign cmd    = cmd_e'(cmd_i);
  assign is_act = (cmd == CMD_ACT);
  assign is_col = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign is_pre = (cmd == CMD_PRE);

  logic [CYC_W-1:0] act_t, pre_t, last_act, win_t;
  logic             bank_open, pre_v, last_act_v, win_v;
  logic [BG_W-1:0]  last_act_bg;
  logic [CYC_W-1:0] col_term, pre_term, act_cand, act_slot, col_time, pre_time;
  logic             col_v;

  assign err_o  = is_col && !bank_open;
  assign accept = issue_i && !err_o;

  dram_bank_table #(.NUM_BANKS(NUM_BANKS), .CYC_W(CYC_W)) u_banks (
    .clk_i, .rst_ni,
    .act_we_i (accept && is_act),
    .pre_we_i (accept && is_pre),
    .bank_i,
    .time_i   (earliest_o),
    .act_t_o  (act_t),
    .open_o   (bank_open),
    .pre_t_o  (pre_t),
    .pre_v_o  (pre_v)
  );

  dram_act_window #(.CYC_W(CYC_W), .BG_W(BG_W), .DEPTH(ACT_HIST)) u_win (
    .clk_i, .rst_ni,
    .push_i    (accept && is_act),
    .time_i    (earliest_o),
    .bg_i,
    .two_win_i (two_act_win_i),
    .cfg_i     (cfg),
    .last_o    (last_act),
    .last_bg_o (last_act_bg),
    .last_v_o  (last_act_v),
    .win_o     (win_t),
    .win_v_o   (win_v)
  );

  dram_col_tracker #(.CYC_W(CYC_W), .BG_W(BG_W), .DEPTH(COL_HIST)) u_col (
    .clk_i, .rst_ni,
    .push_i     (accept && is_col),
    .push_rd_i  (cmd == CMD_RD),
    .time_i     (earliest_o),
    .bg_i,
    .req_rd_i   (cmd == CMD_RD),
    .req_bg_i   (bg_i),
    .grp_mode_i,
    .wr_pad_i,
    .cfg_i      (cfg),
    .cand_i     (act_cand),
    .col_v_o    (col_v),
    .col_term_o (col_term),
    .pre_term_o (pre_term),
    .cand_o     (act_slot)
  );

  logic [CYC_W-1:0] rrd;
  assign rrd = (grp_mode_i && bg_i == last_act_bg) ? ext(cfg.rrd_l) : ext(cfg.rrd_s);

  assign act_cand = vmax(vmax(vmax(now_i, last_act + rrd, last_act_v),
                              pre_t + ext(cfg.rp), pre_v), win_t, win_v);
  assign col_time = vmax(vmax(now_i, act_t + ext(cfg.rcd), bank_open), col_term, col_v);
  assign pre_time = vmax(vmax(now_i, act_t + ext(cfg.ras), bank_open), pre_term, col_v);

  always_comb begin
    unique case (cmd)
      CMD_ACT:         earliest_o = act_slot;
      CMD_RD, CMD_WR:  earliest_o = col_time;
      default:         earliest_o = pre_time;
    endcase
  end
endmodule

// File: rtl/dram_timing_checker_sva.sv
module dram_timing_checker_sva #(
  parameter int unsigned CYC_W  = 16,
  parameter int unsigned BANK_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        cmd_i,
  input logic [BANK_W-1:0] bank_i,
  input logic [CYC_W-1:0]  now_i,
  input logic              issue_i,
  input logic [7:0]        rcd_i,
  input logic [7:0]        ras_i,
  input logic [CYC_W-1:0]  earliest_o,
  input logic              err_o
);
  logic col_now, act_now, pre_now;
  assign act_now = (cmd_i == 2'd0);
  assign col_now = (cmd_i == 2'd1) || (cmd_i == 2'd2);
  assign pre_now = (cmd_i == 2'd3);

  assert_err_col_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> col_now);

  assert_not_before_now_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    earliest_o >= now_i);

  assert_rcd_after_act_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(issue_i && act_now) && col_now && bank_i == $past(bank_i) && $stable(rcd_i))
      |-> ({1'b0, earliest_o} >= {1'b0, $past(earliest_o)} + {{(CYC_W-7){1'b0}}, rcd_i}));

  assert_ras_after_act_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(issue_i && act_now) && pre_now && bank_i == $past(bank_i) && $stable(ras_i))
      |-> ({1'b0, earliest_o} >= {1'b0, $past(earliest_o)} + {{(CYC_W-7){1'b0}}, ras_i}));

  assert_act_skips_col_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(issue_i && col_now && !err_o) && act_now) |-> earliest_o != $past(earliest_o));

  assert_pre_closes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(issue_i && pre_now) && col_now && bank_i == $past(bank_i)) |-> err_o);
endmodule

bind dram_timing_checker dram_timing_checker_sva #(.CYC_W(CYC_W), .BANK_W(BANK_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd_i), .bank_i(bank_i), .now_i(now_i),
  .issue_i(issue_i), .rcd_i(rcd_i), .ras_i(ras_i), .earliest_o(earliest_o), .err_o(err_o)
);

// File: tb/dram_timing_checker_tb_top.sv
`timescale 1ns/1ps
module dram_timing_checker_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  cmd_i = '0;
  logic [3:0]  bank_i = '0;
  logic [1:0]  bg_i = '0;
  logic [15:0] now_i = '0;
  logic        issue_i = 1'b0;
  logic        grp_mode_i = 1'b0, two_act_win_i = 1'b0, wr_pad_i = 1'b0;
  logic [7:0]  ccd_s = 8'd2;
  logic [15:0] earliest_o;
  logic        err_o;
  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  dram_timing_checker dut_i (
    .clk_i(clk), .rst_ni, .cmd_i, .bank_i, .bg_i, .now_i, .issue_i,
    .grp_mode_i, .two_act_win_i, .wr_pad_i,
    .rrd_s_i(8'd2), .rrd_l_i(8'd4), .rp_i(8'd3), .faw_i(8'd12), .taw_i(8'd6),
    .rcd_i(8'd5), .ccd_s_i(ccd_s), .ccd_l_i(8'd4), .wtr_s_i(8'd2), .wtr_l_i(8'd5),
    .ras_i(8'd10), .rtp_i(8'd3), .wr_i(8'd6), .wl_i(8'd4), .rl_i(8'd6), .burst_i(8'd4),
    .earliest_o, .err_o
  );

  localparam logic [1:0] ACT = 2'd0, RD = 2'd1, WR = 2'd2, PRE = 2'd3;

  typedef struct packed {
    logic [1:0]  cmd;
    logic [3:0]  bank;
    logic [15:0] now;
    logic        iss;
    logic        chk_e;
    logic [15:0] exp_e;
    logic        exp_err;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{ACT, 4'd0, 16'd10, 1'b1, 1'b1, 16'd10, 1'b0},
    '{RD,  4'd0, 16'd10, 1'b1, 1'b1, 16'd15, 1'b0},
    '{ACT, 4'd1, 16'd11, 1'b1, 1'b1, 16'd12, 1'b0},
    '{ACT, 4'd2, 16'd12, 1'b1, 1'b1, 16'd14, 1'b0},
    '{ACT, 4'd3, 16'd13, 1'b1, 1'b1, 16'd16, 1'b0},
    '{ACT, 4'd4, 16'd0,  1'b0, 1'b1, 16'd22, 1'b0},
    '{WR,  4'd1, 16'd0,  1'b1, 1'b1, 16'd23, 1'b0},
    '{RD,  4'd0, 16'd0,  1'b0, 1'b1, 16'd33, 1'b0},
    '{PRE, 4'd1, 16'd0,  1'b0, 1'b1, 16'd37, 1'b0},
    '{RD,  4'd5, 16'd0,  1'b1, 1'b0, 16'd0,  1'b1},
    '{RD,  4'd5, 16'd0,  1'b0, 1'b0, 16'd0,  1'b1},
    '{RD,  4'd0, 16'd0,  1'b0, 1'b1, 16'd33, 1'b0},
    '{ACT, 4'd4, 16'd23, 1'b1, 1'b1, 16'd24, 1'b0},
    '{PRE, 4'd0, 16'd0,  1'b1, 1'b1, 16'd37, 1'b0},
    '{ACT, 4'd0, 16'd0,  1'b0, 1'b1, 16'd40, 1'b0},
    '{RD,  4'd0, 16'd0,  1'b0, 1'b0, 16'd0,  1'b1}
  };
  localparam string VTAG [NV] = '{"R1", "R3", "R1", "R1", "R1", "R2", "R3", "R3",
                                  "R5", "R8", "R8", "R8", "R7", "R5", "R1", "R8"};

  task automatic apply(input logic [1:0] c, input int b, input int g, input int n,
                       input logic iss, input logic ce, input int exp_e,
                       input logic exp_err, input string tag);
    @(negedge clk);
    cmd_i = c; bank_i = b[3:0]; bg_i = g[1:0]; now_i = n[15:0]; issue_i = iss;
    #2;
    n_chk++;
    if (err_o !== exp_err) begin
      n_err++;
      $display("FAIL %s err_o actual %0b expected %0b", tag, err_o, exp_err);
    end
    if (ce) begin
      n_chk++;
      if (earliest_o !== exp_e[15:0]) begin
        n_err++;
        $display("FAIL %s earliest_o actual %0d expected %0d", tag, earliest_o, exp_e);
      end
    end
    @(posedge clk); #1 issue_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0; issue_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    do_reset();
    // reset state R9: no history, all banks closed
    apply(ACT, 7, 0, 5, 0, 1, 5, 0, "R9");
    apply(RD,  7, 0, 0, 0, 0, 0, 1, "R9");
    apply(PRE, 3, 0, 9, 0, 1, 9, 0, "R9");

    for (int i = 0; i < NV; i++)
      apply(VEC[i].cmd, int'(VEC[i].bank), 0, int'(VEC[i].now), VEC[i].iss,
            VEC[i].chk_e, int'(VEC[i].exp_e), VEC[i].exp_err, VTAG[i]);

    // bank-group timings R4, pad R6, two-activate window R2
    do_reset();
    grp_mode_i = 1'b1;
    apply(ACT, 0, 0, 0, 1, 1, 0,  0, "R4");
    apply(ACT, 4, 0, 0, 0, 1, 4,  0, "R4");
    apply(ACT, 8, 1, 0, 1, 1, 2,  0, "R4");
    apply(RD,  0, 0, 0, 1, 1, 5,  0, "R3");
    apply(RD,  0, 0, 0, 0, 1, 9,  0, "R4");
    apply(RD,  0, 1, 0, 0, 1, 7,  0, "R4");
    apply(WR,  8, 1, 0, 1, 1, 13, 0, "R3");
    apply(RD,  0, 1, 0, 0, 1, 26, 0, "R4");
    apply(RD,  0, 0, 0, 0, 1, 23, 0, "R3");
    wr_pad_i = 1'b1;
    apply(RD,  0, 0, 0, 0, 1, 24, 0, "R6");
    apply(PRE, 8, 1, 0, 0, 1, 28, 0, "R6");
    wr_pad_i = 1'b0;
    apply(PRE, 8, 1, 0, 0, 1, 27, 0, "R5");
    apply(ACT, 1, 0, 0, 0, 1, 4,  0, "R2");
    two_act_win_i = 1'b1;
    apply(ACT, 1, 0, 0, 0, 1, 6,  0, "R2");
    two_act_win_i = 1'b0;

    // repeated push-back over three adjacent column slots R7
    do_reset();
    grp_mode_i = 1'b0; ccd_s = 8'd1;
    apply(ACT, 0, 0, 0, 1, 1, 0, 0, "R9");
    apply(RD,  0, 0, 0, 1, 1, 5, 0, "R3");
    apply(RD,  0, 0, 0, 1, 1, 6, 0, "R3");
    apply(RD,  0, 0, 0, 1, 1, 7, 0, "R3");
    apply(ACT, 1, 0, 5, 0, 1, 8, 0, "R7");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule